// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent down/up counters behind a small word-addressed register bus. Each channel has a live count, a reload value and two compare values. A shared control register gives every channel a run bit, a choice between the bus clock and an external tick, and an enable that lets its wrap event reach the interrupt. A build parameter picks one of two bit layouts for that control register.

Wrap and compare events latch into a nine-bit status register. Software clears status bits by writing ones. A mask register and the per-channel wrap enables reduce the status to a single interrupt line. The usual uses are a periodic tick, where the reload value sets the period, and a one-shot deadline. For a one-shot, the reload value is all ones and the first compare is written as the live count minus the wanted delay. The external tick is a synchronous one-cycle enable sampled on the bus clock.

Top module: `tmr_top`

## Requirements
- R1: After reset every count, reload, compare, control and status register reads 0, the mask reads 0x1FF and `irq` is low.
- R2: A channel that is running in down mode on the bus clock lowers its count by one on every clock. The count can be read while the channel runs.
- R3: A running down-counter at 0 takes the reload value on its next tick and sets status bit 3k+2 for channel k (k = 0, 1, 2).
- R4: In layout 0, control bit 9 set makes all channels count up. An up-counter at all ones goes to 0 on its next tick and sets status bit 3k+2.
- R5: When a channel's clock-select bit is 1, its count moves only on clocks where `extTick[k]` is high.
- R6: A channel with its run bit clear holds its count. A reload write to a stopped channel also copies the value into the count. A reload write to a running channel leaves the count alone.
- R7: On every clock where channel k runs and its count equals compare 1 (or compare 2), status bit 3k (or 3k+1) is set.
- R8: A status write clears exactly the bits written as 1. The other bits keep their values.
- R9: `irq` is the OR of the status bits whose mask bit is 0. Bit 3k+2 also needs channel k's wrap-interrupt enable.
- R10: In layout 0, channel k's run, clock-select and wrap-enable bits are control bits 3k, 3k+1 and 3k+2. In layout 1 they are bits 4k, 4k+1 and 4k+2, there is no count-direction bit, and counting is always down.
- R11: `addr` is a word index. Channel k uses words 4k (count), 4k+1 (reload), 4k+2 (compare 1) and 4k+3 (compare 2). Control is word 12, status 13, mask 14, and word 15 reads 0. Writes to a count word are ignored.
- R12: The control register reads back only its defined bits: 0x3FF in layout 0 and 0x777 in layout 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word index of the register |
| wrData | input | 32 | Write data |
| extTick | input | 3 | Per-channel external tick enable pulse |
| rdData | output | 32 | Combinational read data of the addressed word |
| irq | output | 1 | Combined interrupt |

## Verification
The counters are driven in four patterns: down on the bus clock through a zero-wrap reload, up from just below all ones through the wrap to zero, gated by sparse external pulses, and stopped. Each of these separates a fault in the step, the wrap value or the tick gating. Compare values are placed at both ends of a count run, so the two compare status bits are set at different times. Mask and wrap-enable combinations are applied while status bits are set, which shows whether the interrupt gating is wrong. A second instance built with the other layout is driven with patterns that enable channels through bits that have meaning in only one of the two layouts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_COUNT = 3;
  localparam int CTRL_W    = 11;
  localparam int ST_W      = 3 * TMR_COUNT;
  localparam int UPDIR_BIT = 9;

  typedef struct packed {
    logic [TMR_COUNT-1:0] loadWe;
    logic [TMR_COUNT-1:0] m1We;
    logic [TMR_COUNT-1:0] m2We;
    logic [TMR_COUNT-1:0] run;
    logic [TMR_COUNT-1:0] useExt;
    logic [TMR_COUNT-1:0] countUp;
  } tmrStrobe_t;

  // fld: 0 run, 1 clock select, 2 wrap-interrupt enable
  function automatic int fieldPos(int layout, int tmr, int fld);
    return ((layout == 0) ? 3 : 4) * tmr + fld;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrlDefMask(int layout);
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int k = 0; k < TMR_COUNT; k++)
      for (int f = 0; f < 3; f++) m[fieldPos(layout, k, f)] = 1'b1;
    if (layout == 0) m[UPDIR_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         useExt,
  input  logic         countUp,
  input  logic         extTick,
  input  logic         loadWe,
  input  logic         m1We,
  input  logic         m2We,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] cntQ,
  output logic [W-1:0] loadQ,
  output logic [W-1:0] m1Q,
  output logic [W-1:0] m2Q,
  output logic         ovfEv,
  output logic         m1Ev,
  output logic         m2Ev
);
  logic tick;
  logic atEnd;

  always_comb begin
    tick  = run & (~useExt | extTick);
    atEnd = countUp ? (&cntQ) : (cntQ == '0);
    ovfEv = tick & atEnd;
    m1Ev  = run & (cntQ == m1Q);
    m2Ev  = run & (cntQ == m2Q);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      loadQ <= '0;
      m1Q   <= '0;
      m2Q   <= '0;
    end else begin
      if (loadWe) loadQ <= wrData;
      if (m1We)   m1Q   <= wrData;
      if (m2We)   m2Q   <= wrData;
      if (loadWe && !run)
        cntQ <= wrData;
      else if (tick) begin
        if (atEnd)        cntQ <= countUp ? '0 : loadQ;
        else if (countUp) cntQ <= cntQ + 1'b1;
        else              cntQ <= cntQ - 1'b1;
      end
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !countUp && !atEnd && !loadWe) |=> cntQ == $past(cntQ) - 1'b1);
  p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !countUp && cntQ == '0) |=> cntQ == $past(loadQ));
  p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && countUp && (&cntQ)) |=> cntQ == '0);
  p_ext_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (run && useExt && !extTick) |=> $stable(cntQ));
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !loadWe) |=> $stable(cntQ));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tmrStrobe_t                 stb,
  input  logic [W-1:0]               wrData,
  input  logic [TMR_COUNT-1:0]       extTick,
  output logic [TMR_COUNT-1:0][W-1:0] cntV,
  output logic [TMR_COUNT-1:0][W-1:0] loadV,
  output logic [TMR_COUNT-1:0][W-1:0] m1V,
  output logic [TMR_COUNT-1:0][W-1:0] m2V,
  output logic [TMR_COUNT-1:0]       ovfEv,
  output logic [TMR_COUNT-1:0]       m1Ev,
  output logic [TMR_COUNT-1:0]       m2Ev
);
  for (genvar k = 0; k < TMR_COUNT; k++) begin : g_chan
    tmr_chan #(.W(W)) u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .run     (stb.run[k]),
      .useExt  (stb.useExt[k]),
      .countUp (stb.countUp[k]),
      .extTick (extTick[k]),
      .loadWe  (stb.loadWe[k]),
      .m1We    (stb.m1We[k]),
      .m2We    (stb.m2We[k]),
      .wrData  (wrData),
      .cntQ    (cntV[k]),
      .loadQ   (loadV[k]),
      .m1Q     (m1V[k]),
      .m2Q     (m2V[k]),
      .ovfEv   (ovfEv[k]),
      .m1Ev    (m1Ev[k]),
      .m2Ev    (m2Ev[k])
    );
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W      = 32,
  parameter int LAYOUT = 0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [3:0]                  addr,
  input  logic [CTRL_W-1:0]           wrLow,
  input  logic [TMR_COUNT-1:0][W-1:0] cntV,
  input  logic [TMR_COUNT-1:0][W-1:0] loadV,
  input  logic [TMR_COUNT-1:0][W-1:0] m1V,
  input  logic [TMR_COUNT-1:0][W-1:0] m2V,
  input  logic [TMR_COUNT-1:0]        ovfEv,
  input  logic [TMR_COUNT-1:0]        m1Ev,
  input  logic [TMR_COUNT-1:0]        m2Ev,
  output tmrStrobe_t                  stb,
  output logic [W-1:0]                rdData,
  output logic                        irq
);
  localparam logic [CTRL_W-1:0] DEF_MASK = ctrlDefMask(LAYOUT);
  localparam logic [1:0]        SYS_BANK = 2'(TMR_COUNT);

  logic [CTRL_W-1:0] ctrlQ;
  logic [ST_W-1:0]   statusQ, maskQ;
  logic [ST_W-1:0]   evVec, irqGate;
  logic [1:0]        bank, sel;
  logic              ctrlWe, stWe, maskWe;

  assign bank = addr[3:2];
  assign sel  = addr[1:0];

  always_comb begin
    stb = '0;
    for (int k = 0; k < TMR_COUNT; k++) begin
      stb.run[k]     = ctrlQ[fieldPos(LAYOUT, k, 0)];
      stb.useExt[k]  = ctrlQ[fieldPos(LAYOUT, k, 1)];
      stb.countUp[k] = (LAYOUT == 0) ? ctrlQ[UPDIR_BIT] : 1'b0;
      if (wrEn && bank == 2'(k)) begin
        stb.loadWe[k] = (sel == 2'd1);
        stb.m1We[k]   = (sel == 2'd2);
        stb.m2We[k]   = (sel == 2'd3);
      end
    end
    ctrlWe = wrEn && bank == SYS_BANK && sel == 2'd0;
    stWe   = wrEn && bank == SYS_BANK && sel == 2'd1;
    maskWe = wrEn && bank == SYS_BANK && sel == 2'd2;
  end

  always_comb begin
    for (int k = 0; k < TMR_COUNT; k++) begin
      evVec[3*k]       = m1Ev[k];
      evVec[3*k+1]     = m2Ev[k];
      evVec[3*k+2]     = ovfEv[k];
      irqGate[3*k]     = 1'b1;
      irqGate[3*k+1]   = 1'b1;
      irqGate[3*k+2]   = ctrlQ[fieldPos(LAYOUT, k, 2)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      statusQ <= '0;
      maskQ   <= '1;
    end else begin
      if (ctrlWe) ctrlQ <= wrLow & DEF_MASK;
      if (maskWe) maskQ <= wrLow[ST_W-1:0];
      statusQ <= (statusQ & ~(stWe ? wrLow[ST_W-1:0] : '0)) | evVec;
    end
  end

  assign irq = |(statusQ & ~maskQ & irqGate);

  always_comb begin
    rdData = '0;
    for (int k = 0; k < TMR_COUNT; k++) begin
      if (bank == 2'(k)) begin
        case (sel)
          2'd0:    rdData = cntV[k];
          2'd1:    rdData = loadV[k];
          2'd2:    rdData = m1V[k];
          default: rdData = m2V[k];
        endcase
      end
    end
    if (bank == SYS_BANK) begin
      case (sel)
        2'd0:    rdData = W'(ctrlQ);
        2'd1:    rdData = W'(statusQ);
        2'd2:    rdData = W'(maskQ);
        default: rdData = '0;
      endcase
    end
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|evVec) |=> ((statusQ & $past(evVec)) == $past(evVec)));
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stWe && evVec == '0) |=> statusQ == ($past(statusQ) & ~$past(wrLow[ST_W-1:0])));
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ == '0 || maskQ == '1) |-> !irq);
  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stWe && evVec == '0) |=> $stable(statusQ));
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int W      = 32,
  parameter int LAYOUT = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [3:0]           addr,
  input  logic [W-1:0]         wrData,
  input  logic [TMR_COUNT-1:0] extTick,
  output logic [W-1:0]         rdData,
  output logic                 irq
);
  tmrStrobe_t                  stb;
  logic [TMR_COUNT-1:0][W-1:0] cntV, loadV, m1V, m2V;
  logic [TMR_COUNT-1:0]        ovfEv, m1Ev, m2Ev;

  tmr_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .extTick (extTick),
    .cntV    (cntV),
    .loadV   (loadV),
    .m1V     (m1V),
    .m2V     (m2V),
    .ovfEv   (ovfEv),
    .m1Ev    (m1Ev),
    .m2Ev    (m2Ev)
  );

  tmr_ctrl #(.W(W), .LAYOUT(LAYOUT)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrLow  (wrData[CTRL_W-1:0]),
    .cntV   (cntV),
    .loadV  (loadV),
    .m1V    (m1V),
    .m2V    (m2V),
    .ovfEv  (ovfEv),
    .m1Ev   (m1Ev),
    .m2Ev   (m2Ev),
    .stb    (stb),
    .rdData (rdData),
    .irq    (irq)
  );
endmodule

// File: tb/tb_tmr_top.sv
module tb_tmr_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrEnB = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  extTick = '0;
  logic [31:0] rdData, rdDataB;
  logic        irq, irqB;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_top #(.W(32), .LAYOUT(0)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .extTick(extTick), .rdData(rdData), .irq(irq));

  tmr_top #(.W(32), .LAYOUT(1)) dutB (
    .clk(clk), .rstN(rstN), .wrEn(wrEnB), .addr(addr), .wrData(wrData),
    .extTick(extTick), .rdData(rdDataB), .irq(irqB));

  // behavioural model of the layout-0 instance
  bit [31:0] mCnt[3], mLoad[3], mM1[3], mM2[3];
  bit [10:0] mCtrl;
  bit [8:0]  mSt, mMask;

  always @(posedge clk) begin : model_b
    bit [8:0]  ev, clr;
    bit [31:0] nc[3];
    bit        en, tk;
    if (!rstN) begin
      for (int k = 0; k < 3; k++) begin
        mCnt[k] = 0; mLoad[k] = 0; mM1[k] = 0; mM2[k] = 0;
      end
      mCtrl = 0; mSt = 0; mMask = 9'h1FF;
    end else begin
      ev = 0; clr = 0;
      for (int k = 0; k < 3; k++) begin
        en = mCtrl[3*k];
        tk = en && (!mCtrl[3*k+1] || extTick[k]);
        nc[k] = mCnt[k];
        if (en && mCnt[k] == mM1[k]) ev[3*k] = 1;
        if (en && mCnt[k] == mM2[k]) ev[3*k+1] = 1;
        if (tk) begin
          if (mCtrl[9]) begin
            if (mCnt[k] == 32'hFFFF_FFFF) begin nc[k] = 0; ev[3*k+2] = 1; end
            else nc[k] = mCnt[k] + 1;
          end else begin
            if (mCnt[k] == 0) begin nc[k] = mLoad[k]; ev[3*k+2] = 1; end
            else nc[k] = mCnt[k] - 1;
          end
        end
      end
      if (wrEn) begin
        if (addr < 12) begin
          case (addr % 4)
            1: begin mLoad[addr/4] = wrData; if (!mCtrl[3*(addr/4)]) nc[addr/4] = wrData; end
            2: mM1[addr/4] = wrData;
            3: mM2[addr/4] = wrData;
            default: ;
          endcase
        end else if (addr == 12) mCtrl = wrData[10:0] & 11'h3FF;
        else if (addr == 13) clr = wrData[8:0];
        else if (addr == 14) mMask = wrData[8:0];
      end
      mSt = (mSt & ~clr) | ev;
      for (int k = 0; k < 3; k++) mCnt[k] = nc[k];
    end
  end

  function automatic bit mIrq();
    bit [8:0] g;
    g = 9'h1FF;
    g[2] = mCtrl[2]; g[5] = mCtrl[5]; g[8] = mCtrl[8];
    return |(mSt & ~mMask & g);
  endfunction

  function automatic bit [31:0] mRead(bit [3:0] a);
    if (a < 12) begin
      case (a % 4)
        0: return mCnt[a/4];
        1: return mLoad[a/4];
        2: return mM1[a/4];
        default: return mM2[a/4];
      endcase
    end
    case (a)
      12: return {21'b0, mCtrl};
      13: return {23'b0, mSt};
      14: return {23'b0, mMask};
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      chk("R9 irq per clock", {31'b0, irq}, {31'b0, mIrq()});
      chk("R11 read per clock", rdData, mRead(addr));
    end
  end

  task automatic wr(input bit [3:0] a, input bit [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic wrB(input bit [3:0] a, input bit [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEnB = 1'b1;
    @(negedge clk); wrEnB = 1'b0;
  endtask

  task automatic rd(input bit [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #3; v = rdData;
  endtask

  task automatic rdB(input bit [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #3; v = rdDataB;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R1 reset value", v, (a == 14) ? 32'h1FF : 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R6 load copies into stopped counter, R11 count word read-only
    wr(4'd1, 32'd10);
    rd(4'd0, v);  chk("R6 load into stopped count", v, 32'd10);
    wr(4'd0, 32'd55);
    rd(4'd0, v);  chk("R11 count write ignored", v, 32'd10);

    // R2 down counting, R3 reload at zero
    wr(4'd12, 32'h1);
    rd(4'd0, v);  chk("R2 first down step", v, 32'd9);
    idle(9);
    rd(4'd0, v);  chk("R3 reload after zero", v, 32'd10);
    rd(4'd13, v); chk("R3 R7 wrap and compare status", v, 32'h7);

    // R6 freeze, R8 write-one-to-clear
    wr(4'd12, 32'h0);
    rd(4'd0, v); idle(4); rd(4'd0, v2);
    chk("R6 stopped count holds", v2, v);
    wr(4'd13, 32'h1);
    rd(4'd13, v); chk("R8 clear only bit 0", v, 32'h6);
    wr(4'd13, 32'h6);
    rd(4'd13, v); chk("R8 clear remaining", v, 32'h0);

    // R6 load while running leaves count
    wr(4'd12, 32'h1);
    wr(4'd1, 32'd1000);
    rd(4'd0, v);  chk("R6 running count not loaded", {31'b0, v < 32'd20}, 32'h1);
    rd(4'd1, v);  chk("R6 reload register written", v, 32'd1000);

    // R7 compares, R9 interrupt gating
    wr(4'd12, 32'h0);
    wr(4'd1, 32'd20);
    wr(4'd2, 32'd15);
    wr(4'd3, 32'd5);
    wr(4'd13, 32'h1FF);
    wr(4'd14, 32'h1FE);
    chk("R9 no status no irq", {31'b0, irq}, 32'h0);
    wr(4'd12, 32'h1);
    idle(30);
    rd(4'd13, v); chk("R7 both compares latched", v & 32'h3, 32'h3);
    chk("R9 unmasked compare raises irq", {31'b0, irq}, 32'h1);
    wr(4'd14, 32'h1FB);
    chk("R9 wrap without enable quiet", {31'b0, irq}, 32'h0);
    wr(4'd12, 32'h5);
    chk("R9 wrap with enable raises irq", {31'b0, irq}, 32'h1);
    wr(4'd12, 32'h0);
    wr(4'd14, 32'h1FF);
    wr(4'd13, 32'h1FF);

    // R4 up counting on channel 1
    wr(4'd5, 32'hFFFF_FFFD);
    wr(4'd12, 32'h208);
    rd(4'd4, v);  chk("R4 up step", v, 32'hFFFF_FFFE);
    rd(4'd4, v);  chk("R4 reaches all ones", v, 32'hFFFF_FFFF);
    rd(4'd4, v);  chk("R4 wraps to zero", v, 32'h0);
    rd(4'd13, v); chk("R4 wrap status bit 5", v, 32'h38);
    wr(4'd12, 32'h0);

    // R5 external tick on channel 2
    wr(4'd9, 32'd100);
    wr(4'd12, 32'hC0);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); extTick = 3'b100;
      @(negedge clk); extTick = 3'b000;
      idle(2);
    end
    rd(4'd8, v);  chk("R5 three external ticks", v, 32'd97);
    wr(4'd12, 32'h0);

    // R12 control readback, layout 0
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd12, v); chk("R12 layout 0 defined bits", v, 32'h3FF);
    wr(4'd12, 32'h0);

    // R10 layout 1 instance
    wrB(4'd12, 32'hFFFF_FFFF);
    rdB(4'd12, v); chk("R10 R12 layout 1 defined bits", v, 32'h777);
    wrB(4'd12, 32'h0);
    wrB(4'd5, 32'd50);
    wrB(4'd12, 32'h8);
    rdB(4'd12, v); chk("R10 bit 3 unused in layout 1", v, 32'h0);
    rdB(4'd4, v);  chk("R10 channel 1 stays stopped", v, 32'd50);
    wrB(4'd12, 32'h210);
    idle(4);
    rdB(4'd4, v);  chk("R10 layout 1 counts down", v, 32'd45);
    rdB(4'd12, v); chk("R10 layout 1 control readback", v, 32'h210);

    idle(3);
    summary();
    $finish;
  end
endmodule